// File: doc/BRIEF.md
# Cascaded Clock Divider Tree

This block builds a family of related clocks from one root. The root is chosen glitch-free between a reference clock input and a PLL clock input. Three integer dividers then derive slower clocks from it. The first and second dividers run off the root. The third runs off the second divider's output, so its ratio multiplies on top of the second divider's ratio.

All control sits in one 32-bit configuration word, written and read back through a plain write-enable/read-data port clocked by the reference clock. Each divider takes its ratio from a packed bit field of that word. It takes up a new ratio only when its current output period ends, and each field is resynchronised into the divider's own clock domain before use.

Top module: `ckdiv_tree`

## Requirements
- R1: Configuration bit 0 selects the root clock: 0 picks `clk_ref` and 1 picks `clk_pll`. `clk_root` then runs at the selected clock's period.
- R2: The first divider (`clk_div[0]`) is clocked from the root and takes its ratio field from configuration bits 5:2.
- R3: The second divider (`clk_div[1]`) is clocked from the root and takes its ratio field from configuration bits 10:7.
- R4: The third divider (`clk_div[2]`) takes its ratio field from configuration bits 17:12. It is clocked from `clk_div[1]`, so its period is the product of both ratios times the root period.
- R5: Each divider's output period is (field + 1) input periods. A field of 0 passes the input clock through unchanged, with the same period and high time.
- R6: The configuration word is 32 bits wide. `rd_data` shows it one `clk_ref` cycle after a write, and bits 1, 6, 11 and 31:18 always read as zero.
- R7: A new divider ratio takes effect only at the end of the output period in progress. A high phase that is already running keeps its old length, and no divider output pulse is shorter than half a root period.
- R8: Switching the root never lets both sources drive it at once, and no `clk_root` pulse is shorter than half the period of the faster source.
- R9: For a divide ratio N of 2 or more, the high phase lasts floor(N/2) input cycles and the low phase lasts the rest. For odd N the high phase is therefore one input cycle shorter than the low phase.
- R10: A synchronous reset clears the configuration word to 0. `rd_data` reads 0, the root returns to `clk_ref`, and all three dividers pass their input through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; also clocks the configuration port |
| clk_pll | input | 1 | PLL output clock, the alternative root source |
| rst | input | 1 | Synchronous active-high reset, `clk_ref` domain |
| wr_en | input | 1 | Writes `wr_data` into the configuration word |
| wr_data | input | 32 | New configuration word |
| rd_data | output | 32 | Registered read-back of the configuration word |
| clk_root | output | 1 | Selected root clock |
| clk_div | output | 3 | Divider outputs: bit 0 first, bit 1 second, bit 2 third (chained) |

## Verification
The bench builds the block with its default field layout (widths 4, 4 and 6 at bits 2, 7 and 12), a 10 ns reference clock and a 6 ns PLL clock. The two clocks have a non-integer period ratio, so every root switch crosses truly unrelated edges. The bench takes the period and high time of every output and compares them with products of ratio and root period that it computes itself. It covers the pass-through, odd and maximum ratios, including the 64 x 8 cascade at the third output. It also records the narrowest pulse seen on every clock output, which exposes runt pulses from mid-period ratio changes and from root switching.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

  localparam int CFG_W   = 32;
  localparam int SEL_BIT = 0;
  localparam int NUM_DIV = 3;

  // Field placement per divider; a negative source means "root clock".
  localparam int DIV_LSB [NUM_DIV] = '{2, 7, 12};
  localparam int DIV_WID [NUM_DIV] = '{4, 4, 6};
  localparam int DIV_SRC [NUM_DIV] = '{-1, -1, 1};

  // Offset of a divider's field inside the packed field bus.
  function automatic int field_off(int d);
    int acc;
    acc = 0;
    for (int k = 0; k < d; k++) acc += DIV_WID[k];
    return acc;
  endfunction

  localparam int FIELDS_W = field_off(NUM_DIV);

  // Bits of the configuration word that hold state.
  function automatic logic [CFG_W-1:0] used_mask();
    logic [CFG_W-1:0] m;
    m = '0;
    m[SEL_BIT] = 1'b1;
    for (int d = 0; d < NUM_DIV; d++)
      for (int b = 0; b < DIV_WID[d]; b++)
        m[DIV_LSB[d] + b] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/ckdiv_cfg_reg.sv
module ckdiv_cfg_reg
  import ckdiv_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [CFG_W-1:0]    wr_data,
  output logic [CFG_W-1:0]    rd_data,
  output logic                sel_o,
  output logic [FIELDS_W-1:0] fields_o
);

  localparam logic [CFG_W-1:0] MASK = used_mask();

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) cfg_q <= wr_data & MASK;
      rd_data <= cfg_q;
    end
  end

  assign sel_o = cfg_q[SEL_BIT];

  for (genvar d = 0; d < NUM_DIV; d++) begin : g_field
    assign fields_o[field_off(d) +: DIV_WID[d]] = cfg_q[DIV_LSB[d] +: DIV_WID[d]];
  end

  // R6: unassigned positions never reach the read port
  assert_unused_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~MASK) == '0);

endmodule

// File: rtl/ckdiv_root_mux.sv
module ckdiv_root_mux (
  input  logic clk_ref,
  input  logic clk_pll,
  input  logic rst,
  input  logic sel,
  output logic clk_root
);

  // Each side requests on its rising edge and commits on its falling edge,
  // after seeing the other side released. Enables change only while the
  // clock they gate is low.
  logic ref_req, ref_en;
  logic pll_req, pll_en;

  always_ff @(posedge clk_ref) ref_req <= ~sel & ~pll_en;
  always_ff @(negedge clk_ref) ref_en  <= ref_req;

  always_ff @(posedge clk_pll) pll_req <= sel & ~ref_en;
  always_ff @(negedge clk_pll) pll_en  <= pll_req;

  assign clk_root = (clk_ref & ref_en) | (clk_pll & pll_en);

  // R8: the two gated sources are never open together
  assert_single_source_R8: assert property (@(posedge clk_ref) disable iff (rst)
    !(ref_en && pll_en));

endmodule

// File: rtl/ckdiv_divider.sv
module ckdiv_divider #(
  parameter int W = 4
) (
  input  logic         clk_in,
  input  logic         rst,
  input  logic [W-1:0] ratio_i,
  output logic         clk_o
);

  logic [W-1:0] sync1, sync2;
  logic [W-1:0] act;
  logic [W-1:0] cnt;
  logic         out_q;
  logic [W:0]   half;
  logic [W:0]   nxt;

  assign half = ({1'b0, act} + {{W{1'b0}}, 1'b1}) >> 1;
  assign nxt  = {1'b0, cnt} + {{W{1'b0}}, 1'b1};

  always_ff @(posedge clk_in) begin
    sync1 <= ratio_i;
    sync2 <= sync1;
    if (rst) begin
      act   <= '0;
      cnt   <= '0;
      out_q <= 1'b0;
    end else if (cnt == act) begin
      cnt   <= '0;
      act   <= sync2;
      out_q <= (sync2 != '0);
    end else begin
      cnt   <= cnt + 1'b1;
      out_q <= (nxt < half);
    end
  end

  assign clk_o = (act == '0) ? clk_in : out_q;

  // R5: the phase counter never passes the active ratio
  assert_count_in_range_R5: assert property (@(posedge clk_in) disable iff (rst)
    cnt <= act);

  // R7: the active ratio only changes at a period boundary
  assert_ratio_held_R7: assert property (@(posedge clk_in) disable iff (rst)
    (cnt != act) |=> $stable(act));

  // R9: each high phase opens a period
  assert_high_starts_period_R9: assert property (@(posedge clk_in) disable iff (rst)
    $rose(out_q) |-> (cnt == '0));

endmodule

// File: rtl/ckdiv_tree.sv
module ckdiv_tree
  import ckdiv_pkg::*;
(
  input  logic               clk_ref,
  input  logic               clk_pll,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [CFG_W-1:0]   wr_data,
  output logic [CFG_W-1:0]   rd_data,
  output logic               clk_root,
  output logic [NUM_DIV-1:0] clk_div
);

  logic                sel;
  logic [FIELDS_W-1:0] fields;

  ckdiv_cfg_reg u_cfg (
    .clk      (clk_ref),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .sel_o    (sel),
    .fields_o (fields)
  );

  ckdiv_root_mux u_mux (
    .clk_ref  (clk_ref),
    .clk_pll  (clk_pll),
    .rst      (rst),
    .sel      (sel),
    .clk_root (clk_root)
  );

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    localparam int W   = DIV_WID[i];
    localparam int OFF = field_off(i);
    logic clk_src;
    logic clk_out;

    if (DIV_SRC[i] < 0) begin : g_from_root
      assign clk_src = clk_root;
    end else begin : g_chained
      assign clk_src = g_div[DIV_SRC[i]].clk_out;
    end

    ckdiv_divider #(.W(W)) u_div (
      .clk_in  (clk_src),
      .rst     (rst),
      .ratio_i (fields[OFF +: W]),
      .clk_o   (clk_out)
    );

    assign clk_div[i] = clk_out;
  end

endmodule

// File: tb/ckdiv_tree_tb_top.sv
module ckdiv_tree_tb_top;

  logic        clk_ref = 1'b0;
  logic        clk_pll = 1'b0;
  logic        rst     = 1'b1;
  logic        wr_en   = 1'b0;
  logic [31:0] wr_data = '0;
  wire  [31:0] rd_data;
  wire         clk_root;
  wire  [2:0]  clk_div;

  always #5 clk_ref = ~clk_ref;
  always #3 clk_pll = ~clk_pll;

  ckdiv_tree dut_i (
    .clk_ref  (clk_ref),
    .clk_pll  (clk_pll),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .clk_root (clk_root),
    .clk_div  (clk_div)
  );

  // index 0..2 dividers, 3 root
  wire [3:0] mon = {clk_root, clk_div};

  int  checks   = 0;
  int  failures = 0;
  bit  done     = 0;
  bit  armed    = 0;
  bit  valid [4];
  real last_t [4];
  real minw   [4];

  // narrowest pulse monitor
  initial begin
    logic [3:0] prev;
    prev = mon;
    for (int k = 0; k < 4; k++) begin valid[k] = 0; minw[k] = 1.0e9; end
    forever begin
      @(mon);
      for (int k = 0; k < 4; k++) begin
        if (mon[k] != prev[k]) begin
          if (armed && valid[k] && ($realtime - last_t[k] < minw[k]))
            minw[k] = $realtime - last_t[k];
          valid[k]  = armed;
          last_t[k] = $realtime;
        end
      end
      prev = mon;
    end
  end

  task automatic check_real(string tag, real act, real exp);
    checks++;
    if (act - exp > 0.01 || exp - act > 0.01) begin
      failures++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", tag, act, exp);
    end
  endtask

  task automatic check_word(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wait_edge(int k, bit lvl);
    while (mon[k] == lvl) @(mon);
    while (mon[k] != lvl) @(mon);
  endtask

  task automatic measure(int k, real exp_p, real exp_h, string tag);
    real t0, t1, t2;
    wait_edge(k, 1'b1); t0 = $realtime;
    wait_edge(k, 1'b0); t1 = $realtime;
    wait_edge(k, 1'b1); t2 = $realtime;
    check_real({tag, " period"}, t2 - t0, exp_p);
    check_real({tag, " high"},   t1 - t0, exp_h);
  endtask

  task automatic cfg_write(logic [31:0] v);
    @(negedge clk_ref);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk_ref);
    wr_en   = 1'b0;
    @(negedge clk_ref);
  endtask

  task automatic settle();
    repeat (30) @(posedge clk_ref);
    repeat (6) wait_edge(2, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    real t0;
    repeat (20) @(negedge clk_ref);
    rst = 1'b0;
    armed = 1;
    @(negedge clk_ref);
    check_word("R10 reset read-back", rd_data, 32'h0);
    measure(3, 10.0, 5.0, "R10 R1 root after reset");
    measure(0, 10.0, 5.0, "R10 R5 div0 after reset");
    measure(1, 10.0, 5.0, "R10 R5 div1 after reset");
    measure(2, 10.0, 5.0, "R10 R5 div2 after reset");

    cfg_write(32'hFFFF_FFFF);
    check_word("R6 unused bits read zero", rd_data, 32'h0003_F7BD);

    // ref root, div0 N=4, div1 N=3, div2 N=5
    cfg_write(32'h0000_410C);
    check_word("R6 read-back", rd_data, 32'h0000_410C);
    settle();
    measure(3, 10.0, 5.0,   "R1 root on ref");
    measure(0, 40.0, 20.0,  "R2 div0 N4");
    measure(1, 30.0, 10.0,  "R3 R9 div1 N3");
    measure(2, 150.0, 60.0, "R4 R9 div2 N5 chained");

    // same ratios, PLL root
    cfg_write(32'h0000_410D);
    settle();
    measure(3, 6.0, 3.0,   "R1 R8 root on pll");
    measure(0, 24.0, 12.0, "R2 div0 on pll");
    measure(1, 18.0, 6.0,  "R9 div1 on pll");
    measure(2, 90.0, 36.0, "R4 div2 on pll");

    // pass-through
    cfg_write(32'h0000_1001);
    settle();
    measure(0, 6.0, 3.0,   "R5 div0 pass-through");
    measure(1, 6.0, 3.0,   "R5 div1 pass-through");
    measure(2, 12.0, 6.0,  "R4 div2 N2 on pass-through");

    // maximum ratios, back on ref
    cfg_write(32'h0003_F3BC);
    settle();
    measure(0, 160.0, 80.0,    "R2 div0 N16");
    measure(1, 80.0, 40.0,     "R3 div1 N8");
    measure(2, 5120.0, 2560.0, "R4 div2 N64 chained");

    // ratio change inside a running high phase
    wait_edge(0, 1'b1); t0 = $realtime;
    repeat (3) @(negedge clk_ref);
    cfg_write(32'h0003_F384);
    wait_edge(0, 1'b0);
    check_real("R7 running high phase kept", $realtime - t0, 80.0);
    settle();
    measure(0, 20.0, 10.0, "R7 R5 div0 new ratio N2");

    // reset while on PLL with odd ratios
    cfg_write(32'h0000_410D);
    settle();
    armed = 0;
    @(negedge clk_ref); rst = 1'b1;
    repeat (20) @(negedge clk_ref);
    rst = 1'b0;
    @(negedge clk_ref);
    check_word("R10 mid-run reset read-back", rd_data, 32'h0);
    armed = 1;
    measure(3, 10.0, 5.0, "R10 root back on ref");
    measure(1, 10.0, 5.0, "R10 div1 divide-by-one");
    measure(2, 10.0, 5.0, "R10 div2 divide-by-one");

    checks++;
    if (minw[3] < 2.99) begin
      failures++;
      $display("FAIL R8 root narrowest pulse actual=%0.2f expected>=3.00", minw[3]);
    end
    for (int k = 0; k < 3; k++) begin
      checks++;
      if (minw[k] < 2.99) begin
        failures++;
        $display("FAIL R7 div%0d narrowest pulse actual=%0.2f expected>=3.00", k, minw[k]);
      end
    end
    finish_run();
  end

endmodule